// File: doc/BRIEF.md
# Event state buffer source controller

This block keeps a two-bit state word for each of a fixed number of interrupt sources and decides whether an incoming event is sent on to a downstream router. The two bits are P (an event has been sent on and awaits end-of-interrupt) and Q (a further event arrived while P was set). The pair folds repeated events into one, so a source never has more than one notification outstanding downstream. Events arrive on a per-source hardware input. Edge-style sources trigger on every cycle the input is high. Level-style sources, chosen by a parameter mask, trigger when the input rises.

Software reaches each source through a load/store window. Source n occupies a region of 2^PAGE_SHIFT bytes starting at n << PAGE_SHIFT. With a shift of 12 or 16, one page serves both triggering and management. With a shift of 13 or 17, the lower half of the region is a trigger page and the upper half, at offset 2^(PAGE_SHIFT-1), is a management page. A load at one of the management offsets returns the state held before the access. The same load may also change that state, which makes each access a read-modify-write that nothing can split. A store can trigger the source or, when enabled, perform end-of-interrupt.

Released events leave as notifications on a valid/ready channel that carries the source number. Pending notifications wait in a per-source request bit and are granted to the lowest source number first.

Top module: `esb_source_ctrl`

## Requirements
- R1: After reset every source holds state 00, and no response or notification is presented.
- R2: A hardware trigger is handled according to the state it finds. In state 00 the source moves to 10 and one notification carrying its number is sent. In state 10 or 11 the source moves to 11 and nothing is sent. In state 01 (off) the source stays 01 and nothing is sent.
- R3: A load at management offset 0x000 performs end-of-interrupt and returns the prior state. From 10 it leaves 00. From 11 it clears both bits, re-fires, and leaves 10 with one new notification. From 00 it leaves 00. From 01 it leaves 01.
- R4: A load at management offset 0x800 returns the state without changing it. Loads at 0xC00, 0xD00, 0xE00 and 0xF00 set the state to 00, 01, 10 and 11 respectively and send no notification. Every load produces a response one cycle later, with the data {6'b0, P, Q} holding the prior state.
- R5: With STORE_EOI_EN set, a store at management offset 0x400 performs end-of-interrupt with the same state effect as R3, and produces no response.
- R6: Source n is addressed at n << PAGE_SHIFT. In two-page mode (shift 13 or 17), any store to the trigger page triggers as in R2, and management offsets sit 2^(PAGE_SHIFT-1) above the region base. A load on the trigger page returns 0xFF and changes nothing.
- R7: A level source triggers on a rising input. At end-of-interrupt, if its input is still high, it re-fires and sends a new notification.
- R8: A load at any offset not defined above, or addressed to a source numbered NUM_SRC or higher, returns 0xFF. Such an access, whether load or store, changes no state.
- R9: Once presented, a notification holds its valid and source number until ready is seen. Each released event is delivered exactly once. Events pending together are delivered lowest source number first.
- R10: When a hardware trigger and a window access hit the same source in the same cycle, the access is applied first and the trigger is applied to the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | NUM_SRC | Per-source event input: a pulse for edge sources, a level for level sources |
| req_valid | input | 1 | Window access strobe, one cycle per access |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | PAGE_SHIFT+IDX_W | Byte address in the window |
| rsp_valid | output | 1 | Load response valid, one cycle after the load |
| rsp_data | output | 8 | Prior state {6'b0,P,Q}, or 0xFF for an undefined access |
| notify_valid | output | 1 | Notification valid |
| notify_ready | input | 1 | Downstream accepts the notification |
| notify_src | output | IDX_W | Number of the notifying source |

## Verification
The state machine is driven from each of its four states by every stimulus it accepts: hardware pulses, a level input held high and then dropped, trigger-page stores, end-of-interrupt loads and stores, and set loads. Each stimulus is followed by a read-back load, so each input pattern separates a wrong next state from a wrong returned prior state, and a missing notification from a spurious one. Accesses at undefined offsets, to the trigger page, and to sources beyond the last are each followed by a read of the state they could have changed. A stalled notification channel with two sources firing together shows both grant order and hold behaviour. Finally, a trigger that coincides with an end-of-interrupt on the same source yields state 11 only if the access is applied before the trigger.

// File: rtl/esb_pkg.sv
// Shared types and encodings for the event state buffer source controller.
// Assumes the two-bit state is {P,Q} with P in bit 1.
package esb_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_TRIG,
        OP_EOI,
        OP_GET,
        OP_SET
    } esb_op_e;

    typedef struct packed {
        esb_op_e    op;
        logic [1:0] pq;     // target state for OP_SET
    } esb_cmd_t;

    typedef struct packed {
        logic [1:0] pq;
        logic       fire;
    } pq_step_t;

    localparam logic [1:0]  PQ_IDLE   = 2'b00;
    localparam logic [1:0]  PQ_OFF    = 2'b01;
    localparam logic [1:0]  PQ_PEND   = 2'b10;
    localparam logic [1:0]  PQ_QUEUED = 2'b11;

    localparam logic [11:0] OFS_LD_EOI = 12'h000;
    localparam logic [11:0] OFS_ST_EOI = 12'h400;
    localparam logic [11:0] OFS_GET    = 12'h800;
    localparam logic [7:0]  RSP_BAD    = 8'hFF;

    // Next state and notify decision for one trigger applied to a state.
    function automatic pq_step_t pq_trigger(logic [1:0] pq);
        pq_step_t r;
        case (pq)
            PQ_IDLE: begin r.pq = PQ_PEND;   r.fire = 1'b1; end
            PQ_OFF:  begin r.pq = PQ_OFF;    r.fire = 1'b0; end
            default: begin r.pq = PQ_QUEUED; r.fire = 1'b0; end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/esb_addr_decode.sv
// Window address decoder. Splits an access into a source number and an
// operation. Assumes PAGE_SHIFT is one of 12, 13, 16, 17; 13 and 17
// select the two-page layout. Out-of-range sources and undefined offsets
// decode to OP_NONE.
module esb_addr_decode
    import esb_pkg::*;
#(
    parameter int NUM_SRC      = 6,
    parameter int PAGE_SHIFT   = 13,
    parameter int IDX_W        = 4,
    parameter bit STORE_EOI_EN = 1'b1
) (
    input  logic                        req_valid,
    input  logic                        req_we,
    input  logic [PAGE_SHIFT+IDX_W-1:0] req_addr,
    output logic [IDX_W-1:0]            src_idx,
    output logic                        is_load,
    output esb_cmd_t                    cmd
);
    localparam bit TWO_PAGE = (PAGE_SHIFT == 13) || (PAGE_SHIFT == 17);
    localparam int OFS_W    = TWO_PAGE ? PAGE_SHIFT - 1 : PAGE_SHIFT;

    logic [OFS_W-1:0] ofs;
    logic             mg_page;
    logic             tr_page;
    logic             in_range;
    logic             is_set;

    assign ofs      = req_addr[OFS_W-1:0];
    assign src_idx  = req_addr[PAGE_SHIFT+IDX_W-1:PAGE_SHIFT];
    assign in_range = (src_idx < IDX_W'(NUM_SRC));
    assign is_load  = req_valid && !req_we;
    assign is_set   = (ofs[OFS_W-1:10] == (OFS_W-10)'(3)) && (ofs[7:0] == 8'h00);

    // Page role: split halves in two-page mode, shared page otherwise.
    generate
        if (TWO_PAGE) begin : g_two
            assign mg_page = req_addr[PAGE_SHIFT-1];
            assign tr_page = !req_addr[PAGE_SHIFT-1];
        end else begin : g_one
            assign mg_page = 1'b1;
            assign tr_page = 1'b1;
        end
    endgenerate

    // Operation select for one access.
    always_comb begin
        cmd.op = OP_NONE;
        cmd.pq = ofs[9:8];
        if (req_valid && in_range) begin
            if (req_we) begin
                if (mg_page && ofs == OFS_W'(OFS_ST_EOI))
                    cmd.op = STORE_EOI_EN ? OP_EOI : OP_NONE;
                else if (tr_page)
                    cmd.op = OP_TRIG;
            end else if (mg_page) begin
                if (ofs == OFS_W'(OFS_LD_EOI))   cmd.op = OP_EOI;
                else if (ofs == OFS_W'(OFS_GET)) cmd.op = OP_GET;
                else if (is_set)                 cmd.op = OP_SET;
            end
        end
    end

endmodule

// File: rtl/esb_pq_cell.sv
// State cell for one source. Holds {P,Q} and, for level sources, the last
// sampled input. A window command is applied first, then the hardware
// trigger is applied to that result. At most one notify per cycle.
module esb_pq_cell
    import esb_pkg::*;
#(
    parameter bit IS_LEVEL = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       src_in,
    input  logic       sel,
    input  esb_cmd_t   cmd,
    output logic [1:0] pq,
    output logic       fire
);
    logic [1:0] pq_q;
    logic [1:0] pq_mid;
    logic [1:0] pq_nxt;
    logic       lvl_q;
    logic       hw_trig;
    logic       fire_cmd;
    logic       fire_hw;
    logic       retrig;
    pq_step_t   st_cmd;
    pq_step_t   st_hw;

    assign pq      = pq_q;
    assign hw_trig = IS_LEVEL ? (src_in && !lvl_q) : src_in;
    assign st_cmd  = pq_trigger(pq_q);
    assign st_hw   = pq_trigger(pq_mid);
    assign fire    = fire_cmd || fire_hw;

    // Effect of the window command on the stored state.
    always_comb begin
        pq_mid   = pq_q;
        fire_cmd = 1'b0;
        retrig   = pq_q[0] || (IS_LEVEL && lvl_q);
        if (sel) begin
            case (cmd.op)
                OP_TRIG: begin
                    pq_mid   = st_cmd.pq;
                    fire_cmd = st_cmd.fire;
                end
                OP_EOI: begin
                    if (pq_q != PQ_OFF) begin
                        pq_mid   = retrig ? PQ_PEND : PQ_IDLE;
                        fire_cmd = retrig;
                    end
                end
                OP_SET:  pq_mid = cmd.pq;
                default: pq_mid = pq_q;
            endcase
        end
    end

    // Hardware trigger applied after the command.
    always_comb begin
        pq_nxt  = pq_mid;
        fire_hw = 1'b0;
        if (hw_trig) begin
            pq_nxt  = st_hw.pq;
            fire_hw = st_hw.fire;
        end
    end

    // State and level-sample registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pq_q  <= PQ_IDLE;
            lvl_q <= 1'b0;
        end else begin
            pq_q  <= pq_nxt;
            lvl_q <= src_in;
        end
    end

endmodule

// File: rtl/esb_notify_arb.sv
// Notification queue. One request bit per source collects fires; the
// lowest set bit is moved into a held output register whenever that
// register is empty or being accepted.
module esb_notify_arb #(
    parameter int NUM_SRC = 6,
    parameter int IDX_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] fire,
    input  logic               notify_ready,
    output logic               notify_valid,
    output logic [IDX_W-1:0]   notify_src
);
    logic [NUM_SRC-1:0] req_q;
    logic [NUM_SRC-1:0] clr;
    logic [IDX_W-1:0]   pick;
    logic               any;
    logic               load;

    assign load = any && (!notify_valid || notify_ready);

    // Lowest-numbered pending request.
    always_comb begin
        pick = '0;
        any  = 1'b0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req_q[i]) begin
                pick = IDX_W'(i);
                any  = 1'b1;
            end
        end
    end

    // Request bit cleared when it is moved to the output.
    always_comb begin
        for (int i = 0; i < NUM_SRC; i++)
            clr[i] = load && (pick == IDX_W'(i));
    end

    // Request bits and held output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q        <= '0;
            notify_valid <= 1'b0;
            notify_src   <= '0;
        end else begin
            req_q <= (req_q & ~clr) | fire;
            if (load) begin
                notify_valid <= 1'b1;
                notify_src   <= pick;
            end else if (notify_ready) begin
                notify_valid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/esb_source_ctrl.sv
// Top of the event state buffer source controller: decoder, one state
// cell per source, the notification queue, and the registered load
// response. Assumes one window access per cycle at most.
module esb_source_ctrl
    import esb_pkg::*;
#(
    parameter int                 NUM_SRC      = 6,
    parameter int                 PAGE_SHIFT   = 13,
    parameter bit                 STORE_EOI_EN = 1'b1,
    parameter logic [NUM_SRC-1:0] LEVEL_MASK   = 6'b110000,
    parameter int                 IDX_W        = $clog2(NUM_SRC) + 1,
    parameter int                 ADDR_W       = PAGE_SHIFT + IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               req_valid,
    input  logic               req_we,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic               rsp_valid,
    output logic [7:0]         rsp_data,
    output logic               notify_valid,
    input  logic               notify_ready,
    output logic [IDX_W-1:0]   notify_src
);
    logic [IDX_W-1:0]   src_idx;
    logic               is_load;
    esb_cmd_t           cmd;
    logic [1:0]         pq_all [NUM_SRC];
    logic [NUM_SRC-1:0] fire;
    logic [1:0]         old_pq;
    logic               reads_state;

    esb_addr_decode #(
        .NUM_SRC(NUM_SRC), .PAGE_SHIFT(PAGE_SHIFT),
        .IDX_W(IDX_W), .STORE_EOI_EN(STORE_EOI_EN)
    ) u_dec (
        .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
        .src_idx(src_idx), .is_load(is_load), .cmd(cmd)
    );

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
            esb_pq_cell #(.IS_LEVEL(LEVEL_MASK[i])) u_cell (
                .clk(clk), .rst_n(rst_n), .src_in(src_in[i]),
                .sel(src_idx == IDX_W'(i)), .cmd(cmd),
                .pq(pq_all[i]), .fire(fire[i])
            );
        end
    endgenerate

    esb_notify_arb #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .fire(fire),
        .notify_ready(notify_ready),
        .notify_valid(notify_valid), .notify_src(notify_src)
    );

    // Prior state of the addressed source.
    always_comb begin
        old_pq = PQ_IDLE;
        for (int i = 0; i < NUM_SRC; i++)
            if (src_idx == IDX_W'(i)) old_pq = pq_all[i];
    end

    assign reads_state = (cmd.op == OP_EOI) || (cmd.op == OP_GET) || (cmd.op == OP_SET);

    // Registered load response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= is_load;
            rsp_data  <= reads_state ? {6'b0, old_pq} : RSP_BAD;
        end
    end

endmodule

// File: rtl/esb_source_ctrl_chk.sv
// Port-level checker for the source controller, attached by bind.
module esb_source_ctrl_chk #(
    parameter int NUM_SRC    = 6,
    parameter int PAGE_SHIFT = 13,
    parameter int IDX_W      = 4,
    parameter int ADDR_W     = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_we,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic [7:0]        rsp_data,
    input logic              notify_valid,
    input logic              notify_ready,
    input logic [IDX_W-1:0]  notify_src
);
    p_notify_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        notify_valid && !notify_ready |=> notify_valid && $stable(notify_src));

    p_notify_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        notify_valid |-> notify_src < IDX_W'(NUM_SRC));

    p_rsp_after_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_we |=> rsp_valid);

    p_no_spurious_rsp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_we) |=> !rsp_valid);

    p_rsp_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_data <= 8'd3) || (rsp_data == 8'hFF));

    p_oob_all_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_we && (req_addr[ADDR_W-1:PAGE_SHIFT] >= IDX_W'(NUM_SRC))
        |=> rsp_data == 8'hFF);

endmodule

bind esb_source_ctrl esb_source_ctrl_chk #(
    .NUM_SRC(NUM_SRC), .PAGE_SHIFT(PAGE_SHIFT), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .notify_valid(notify_valid), .notify_ready(notify_ready),
    .notify_src(notify_src)
);

// File: tb/esb_source_ctrl_test.sv
`timescale 1ns/100ps
// Scoreboard bench: tasks push expected responses and notifications,
// a negedge monitor pops and compares them.
module esb_source_ctrl_test;
    localparam int NUM_SRC = 6;
    localparam int SHIFT   = 13;
    localparam int IDX_W   = $clog2(NUM_SRC) + 1;
    localparam int ADDR_W  = SHIFT + IDX_W;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NUM_SRC-1:0] src_in = '0;
    logic               req_valid = 1'b0;
    logic               req_we = 1'b0;
    logic [ADDR_W-1:0]  req_addr = '0;
    logic               rsp_valid;
    logic [7:0]         rsp_data;
    logic               notify_valid;
    logic               notify_ready = 1'b1;
    logic [IDX_W-1:0]   notify_src;

    int    n_chk = 0;
    int    n_bad = 0;
    int    rsp_exp[$];
    string rsp_tag[$];
    int    ntf_exp[$];
    string ntf_tag[$];

    always #2.5 clk = ~clk;

    esb_source_ctrl #(
        .NUM_SRC(NUM_SRC), .PAGE_SHIFT(SHIFT),
        .STORE_EOI_EN(1'b1), .LEVEL_MASK(6'b110000)
    ) uut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in),
        .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .notify_valid(notify_valid), .notify_ready(notify_ready),
        .notify_src(notify_src)
    );

    task automatic chk(input bit ok, input string tag, input int got, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] mk(input int s, input bit mg, input logic [11:0] ofs);
        logic [ADDR_W-1:0] a;
        a = ADDR_W'(s) << SHIFT;
        if (mg) a = a | (ADDR_W'(1) << (SHIFT - 1));
        return a | ADDR_W'(ofs);
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic ld(input int s, input bit mg, input logic [11:0] ofs,
                      input int exp, input string tag);
        rsp_exp.push_back(exp);
        rsp_tag.push_back(tag);
        step();
        req_valid = 1'b1; req_we = 1'b0; req_addr = mk(s, mg, ofs);
        step();
        req_valid = 1'b0;
    endtask

    task automatic st(input int s, input bit mg, input logic [11:0] ofs);
        step();
        req_valid = 1'b1; req_we = 1'b1; req_addr = mk(s, mg, ofs);
        step();
        req_valid = 1'b0; req_we = 1'b0;
    endtask

    task automatic pulse(input int s);
        step();
        src_in[s] = 1'b1;
        step();
        src_in[s] = 1'b0;
    endtask

    task automatic want_ntf(input int s, input string tag);
        ntf_exp.push_back(s);
        ntf_tag.push_back(tag);
    endtask

    task automatic idle(input int n);
        repeat (n) step();
    endtask

    // Monitor: compare every response and accepted notification.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_valid) begin
                if (rsp_exp.size() == 0) chk(1'b0, "R4 unexpected response", rsp_data, 0);
                else begin
                    int e;
                    string t;
                    e = rsp_exp.pop_front();
                    t = rsp_tag.pop_front();
                    chk(rsp_data == 8'(e), t, rsp_data, e);
                end
            end
            if (notify_valid && notify_ready) begin
                if (ntf_exp.size() == 0) chk(1'b0, "R9 unexpected notification", notify_src, 0);
                else begin
                    int e;
                    string t;
                    e = ntf_exp.pop_front();
                    t = ntf_tag.pop_front();
                    chk(notify_src == IDX_W'(e), t, notify_src, e);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rsp_valid, "R1 rsp_valid after reset", rsp_valid, 0);
        chk(!notify_valid, "R1 notify_valid after reset", notify_valid, 0);
        for (int s = 0; s < NUM_SRC; s++) ld(s, 1, 12'h800, 0, "R1 reset state");

        // R2 trigger from each state
        want_ntf(0, "R2 first trigger notifies");
        pulse(0);
        ld(0, 1, 12'h800, 2, "R2 00 to 10");
        pulse(0);
        ld(0, 1, 12'h800, 3, "R2 10 to 11");
        pulse(0);
        ld(0, 1, 12'h800, 3, "R2 11 stays 11");

        // R3 end-of-interrupt
        want_ntf(0, "R3 re-fire from 11");
        ld(0, 1, 12'h000, 3, "R3 eoi returns 11");
        ld(0, 1, 12'h800, 2, "R3 after eoi on 11");
        ld(0, 1, 12'h000, 2, "R3 eoi returns 10");
        ld(0, 1, 12'h800, 0, "R3 after eoi on 10");

        // R4 set loads, off state
        ld(2, 1, 12'hD00, 0, "R4 set 01 returns prior");
        pulse(2);
        ld(2, 1, 12'h800, 1, "R2 off ignores trigger");
        ld(2, 1, 12'h000, 1, "R3 eoi on off returns 01");
        ld(2, 1, 12'h800, 1, "R3 off kept after eoi");
        ld(2, 1, 12'hF00, 1, "R4 set 11 returns prior");
        ld(2, 1, 12'hE00, 3, "R4 set 10 returns prior");
        ld(2, 1, 12'hC00, 2, "R4 set 00 returns prior");
        ld(2, 1, 12'h800, 0, "R4 state after set 00");

        // R5 store end-of-interrupt
        want_ntf(1, "R5 trigger src1");
        pulse(1);
        st(1, 1, 12'h400);
        ld(1, 1, 12'h800, 0, "R5 store eoi cleared");

        // R6 trigger page
        want_ntf(1, "R6 trigger page store");
        st(1, 0, 12'h123);
        ld(1, 1, 12'h800, 2, "R6 store on trigger page");
        ld(1, 0, 12'h800, 8'hFF, "R6 load on trigger page");
        ld(1, 1, 12'h800, 2, "R6 trigger-page load left state");
        ld(1, 1, 12'hC00, 2, "R6 cleanup");

        // R8 undefined accesses
        ld(1, 1, 12'h900, 8'hFF, "R8 undefined offset");
        ld(6, 1, 12'h800, 8'hFF, "R8 source out of range");
        ld(6, 1, 12'hF00, 8'hFF, "R8 out-of-range set");
        st(7, 0, 12'h000);
        st(1, 1, 12'h900);
        ld(1, 1, 12'hD40, 8'hFF, "R8 near-set offset");
        ld(1, 1, 12'h800, 0, "R8 state untouched");

        // R7 level source
        want_ntf(4, "R7 level rise");
        step();
        src_in[4] = 1'b1;
        ld(4, 1, 12'h800, 2, "R7 level pending");
        want_ntf(4, "R7 re-fire while high");
        ld(4, 1, 12'h000, 2, "R7 eoi while high");
        ld(4, 1, 12'h800, 2, "R7 pending again");
        step();
        src_in[4] = 1'b0;
        ld(4, 1, 12'h000, 2, "R7 eoi after drop");
        ld(4, 1, 12'h800, 0, "R7 idle after drop");

        // R9 backpressure and order
        step();
        notify_ready = 1'b0;
        want_ntf(1, "R9 lowest first");
        want_ntf(3, "R9 second");
        src_in[1] = 1'b1; src_in[3] = 1'b1;
        step();
        src_in[1] = 1'b0; src_in[3] = 1'b0;
        idle(4);
        @(negedge clk);
        chk(notify_valid && notify_src == IDX_W'(1), "R9 held during stall", notify_src, 1);
        idle(3);
        @(negedge clk);
        chk(notify_valid && notify_src == IDX_W'(1), "R9 still held", notify_src, 1);
        step();
        notify_ready = 1'b1;
        idle(6);
        ld(1, 1, 12'hC00, 2, "R9 cleanup src1");
        ld(3, 1, 12'hC00, 2, "R9 cleanup src3");

        // R10 same-cycle access and trigger
        want_ntf(0, "R10 setup");
        pulse(0);
        pulse(0);
        want_ntf(0, "R10 eoi re-fire");
        rsp_exp.push_back(3);
        rsp_tag.push_back("R10 eoi prior state");
        step();
        req_valid = 1'b1; req_we = 1'b0; req_addr = mk(0, 1, 12'h000);
        src_in[0] = 1'b1;
        step();
        req_valid = 1'b0; src_in[0] = 1'b0;
        ld(0, 1, 12'h800, 3, "R10 access then trigger");

        idle(20);
        chk(rsp_exp.size() == 0, "R4 responses drained", rsp_exp.size(), 0);
        chk(ntf_exp.size() == 0, "R9 notifications drained", ntf_exp.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule